// File: doc/BRIEF.md
# Fixed-Priority Shared Word Memory

This block lets two agents share one synchronous word store. The primary agent always has precedence. The secondary agent gets the store only while the primary agent is idle. Each agent has an active-low request input and an active-low busy output. A busy output that is low means "you own the store this cycle". Both busy outputs are combinational functions of the two requests, so an agent learns its grant in the same cycle it asks.

Only the owning side's address, write data and strobes reach the store. The primary side presents an address, write data and a write strobe that have already been decoded. The secondary side has an address, data, a write/read select and an active-low chip enable. Writes land on the rising clock edge. Reads are registered: each side has its own read-data register, which is loaded one clock after that side presents a read address. A secondary agent that finds itself held off keeps its request low and simply waits until its busy line drops.

Top module: `shared_word_mem`

## Requirements
- R1: When `pri_req_n` is 0, `pri_busy_n` is 0 and `sec_busy_n` is 1, whatever the value of `sec_req_n`.
- R2: When `pri_req_n` is 1 and `sec_req_n` is 0, `sec_busy_n` is 0 and `pri_busy_n` is 1.
- R3: When both requests are 1, both busy outputs are 1 and the store is neither read nor written, whatever the strobes are.
- R4: Busy outputs follow the requests combinationally, within the same cycle and with no clock edge.
- R5: While the primary side owns the store, `pri_wr_n` = 0 writes `pri_wdata` to `pri_addr` at the rising edge, and `pri_wr_n` = 1 reads `pri_addr`.
- R6: While the secondary side owns the store, `sec_ce_n` = 0 with `sec_wr_n` = 0 writes `sec_wdata` to `sec_addr`, and `sec_ce_n` = 0 with `sec_wr_n` = 1 reads `sec_addr`. With `sec_ce_n` = 1 there is no access.
- R7: Data read at an edge appears on that side's read-data output after that edge. The value returned is the word held before any write at the same edge.
- R8: Strobes from a side that does not own the store have no effect. A side's read-data output holds its value in every cycle that side does not perform a read.
- R9: A secondary request that is held off by the primary side is served in the first cycle after `pri_req_n` returns to 1. The only acknowledgement is `sec_busy_n` going low.
- R10: After reset both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_req_n | input | 1 | Primary request, active low |
| pri_busy_n | output | 1 | Primary grant, low when primary owns the store |
| pri_addr | input | ADDR_W | Primary word address |
| pri_wdata | input | DATA_W | Primary write data |
| pri_wr_n | input | 1 | Primary strobe: 0 write, 1 read |
| pri_rdata | output | DATA_W | Primary read data, registered |
| sec_req_n | input | 1 | Secondary request, active low |
| sec_busy_n | output | 1 | Secondary grant, low when secondary owns the store |
| sec_addr | input | ADDR_W | Secondary word address |
| sec_wdata | input | DATA_W | Secondary write data |
| sec_wr_n | input | 1 | Secondary select: 0 write, 1 read |
| sec_ce_n | input | 1 | Secondary chip enable, active low |
| sec_rdata | output | DATA_W | Secondary read data, registered |

## Verification
The case that decides correctness is both sides asking for the store in the same cycle, each with a live strobe that targets a different word. The bench provokes this repeatedly, both on purpose and in a long random mix. It judges the outcome in two ways:
- it checks the busy pair in that cycle;
- it reads back both target words later, to prove that only the primary write landed and that the held-off secondary write landed only after the primary side let go.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_PRI  = 2'b01,
        OWN_SEC  = 2'b10
    } owner_e;
endpackage

// File: rtl/prio_grant.sv
module prio_grant
    import shmem_pkg::*;
(
    input  logic   pri_req_n,
    input  logic   sec_req_n,
    output logic   pri_busy_n,
    output logic   sec_busy_n,
    output owner_e owner
);
    // Primary wins outright; secondary only when primary is idle.
    always_comb begin
        if (!pri_req_n) begin
            owner = OWN_PRI;
        end else if (!sec_req_n) begin
            owner = OWN_SEC;
        end else begin
            owner = OWN_NONE;
        end
        pri_busy_n = (owner != OWN_PRI);
        sec_busy_n = (owner != OWN_SEC);
    end
endmodule

// File: rtl/access_steer.sv
module access_steer
    import shmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  owner_e              owner,
    input  logic [ADDR_W-1:0]   pri_addr,
    input  logic [DATA_W-1:0]   pri_wdata,
    input  logic                pri_wr_n,
    input  logic [ADDR_W-1:0]   sec_addr,
    input  logic [DATA_W-1:0]   sec_wdata,
    input  logic                sec_wr_n,
    input  logic                sec_ce_n,
    output logic [ADDR_W-1:0]   port_addr,
    output logic [DATA_W-1:0]   port_wdata,
    output logic                port_we,
    output logic                port_re
);
    always_comb begin
        port_addr  = '0;
        port_wdata = '0;
        port_we    = 1'b0;
        port_re    = 1'b0;
        unique case (owner)
            OWN_PRI: begin
                port_addr  = pri_addr;
                port_wdata = pri_wdata;
                port_we    = !pri_wr_n;
                port_re    = pri_wr_n;
            end
            OWN_SEC: begin
                port_addr  = sec_addr;
                port_wdata = sec_wdata;
                port_we    = !sec_ce_n && !sec_wr_n;
                port_re    = !sec_ce_n && sec_wr_n;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/word_store.sv
module word_store
    import shmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  owner_e            owner,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] port_wdata,
    input  logic              port_we,
    input  logic              port_re,
    output logic [DATA_W-1:0] pri_rdata,
    output logic [DATA_W-1:0] sec_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] pri_rd;
        logic [DATA_W-1:0] sec_rd;
    } rd_state_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_state_t         st_d, st_q;
    logic [DATA_W-1:0] word_at;

    assign word_at = mem_q[port_addr];

    always_comb begin
        st_d = st_q;
        if (port_re && owner == OWN_PRI) st_d.pri_rd = word_at;
        if (port_re && owner == OWN_SEC) st_d.sec_rd = word_at;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (port_we) mem_q[port_addr] <= port_wdata;
    end

    assign pri_rdata = st_q.pri_rd;
    assign sec_rdata = st_q.sec_rd;

    p_pri_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != OWN_PRI) |=> $stable(pri_rdata));
    p_sec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != OWN_SEC) |=> $stable(sec_rdata));
    p_we_re_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_we && port_re));
endmodule

// File: rtl/shared_word_mem.sv
module shared_word_mem
    import shmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_req_n,
    output logic              pri_busy_n,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic [DATA_W-1:0] pri_wdata,
    input  logic              pri_wr_n,
    output logic [DATA_W-1:0] pri_rdata,
    input  logic              sec_req_n,
    output logic              sec_busy_n,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [DATA_W-1:0] sec_wdata,
    input  logic              sec_wr_n,
    input  logic              sec_ce_n,
    output logic [DATA_W-1:0] sec_rdata
);
    owner_e            owner;
    logic [ADDR_W-1:0] port_addr;
    logic [DATA_W-1:0] port_wdata;
    logic              port_we;
    logic              port_re;

    prio_grant u_grant (
        .pri_req_n  (pri_req_n),
        .sec_req_n  (sec_req_n),
        .pri_busy_n (pri_busy_n),
        .sec_busy_n (sec_busy_n),
        .owner      (owner)
    );

    access_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
        .owner      (owner),
        .pri_addr   (pri_addr),
        .pri_wdata  (pri_wdata),
        .pri_wr_n   (pri_wr_n),
        .sec_addr   (sec_addr),
        .sec_wdata  (sec_wdata),
        .sec_wr_n   (sec_wr_n),
        .sec_ce_n   (sec_ce_n),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_we    (port_we),
        .port_re    (port_re)
    );

    word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (owner),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_we    (port_we),
        .port_re    (port_re),
        .pri_rdata  (pri_rdata),
        .sec_rdata  (sec_rdata)
    );

    p_pri_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_req_n |-> (!pri_busy_n && sec_busy_n));
    p_sec_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_req_n && !sec_req_n) |-> (!sec_busy_n && pri_busy_n));
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_req_n && sec_req_n) |-> (!port_we && !port_re));
    p_ce_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_busy_n && sec_ce_n) |-> (!port_we && !port_re));
    p_pri_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pri_busy_n && !pri_wr_n) |-> (port_we && port_addr == pri_addr));
    p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~pri_busy_n, ~sec_busy_n}));
endmodule

// File: tb/sim_shared_word_mem.sv
module sim_shared_word_mem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pri_req_n = 1'b1, pri_wr_n = 1'b1;
    logic [7:0] pri_addr = '0, pri_wdata = '0;
    logic       sec_req_n = 1'b1, sec_wr_n = 1'b1, sec_ce_n = 1'b1;
    logic [7:0] sec_addr = '0, sec_wdata = '0;
    logic       pri_busy_n, sec_busy_n;
    logic [7:0] pri_rdata, sec_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] exp_p = '0, exp_s = '0;

    always #2 clk = ~clk;

    shared_word_mem u0 (
        .clk(clk), .rst_n(rst_n),
        .pri_req_n(pri_req_n), .pri_busy_n(pri_busy_n), .pri_addr(pri_addr),
        .pri_wdata(pri_wdata), .pri_wr_n(pri_wr_n), .pri_rdata(pri_rdata),
        .sec_req_n(sec_req_n), .sec_busy_n(sec_busy_n), .sec_addr(sec_addr),
        .sec_wdata(sec_wdata), .sec_wr_n(sec_wr_n), .sec_ce_n(sec_ce_n),
        .sec_rdata(sec_rdata)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, check grants, then rdata at the next falling edge.
    task automatic cyc(input logic pr, input logic pw, input logic [7:0] pa, input logic [7:0] pd,
                       input logic sr, input logic sw, input logic sc,
                       input logic [7:0] sa, input logic [7:0] sd, input string tag);
        logic gp, gs;
        string gt;
        pri_req_n = pr; pri_wr_n = pw; pri_addr = pa; pri_wdata = pd;
        sec_req_n = sr; sec_wr_n = sw; sec_ce_n = sc; sec_addr = sa; sec_wdata = sd;
        #1;
        gp = !pr;
        gs = pr && !sr;
        gt = gp ? "R1" : (gs ? "R2" : "R3");
        chk(pri_busy_n === !gp, {gt, " R4 pri_busy_n"}, int'(pri_busy_n), int'(!gp));
        chk(sec_busy_n === !gs, {gt, " R4 sec_busy_n"}, int'(sec_busy_n), int'(!gs));
        if (gp && pw) exp_p = ref_mem[pa];
        if (gs && !sc && sw) exp_s = ref_mem[sa];
        if (gp && !pw) ref_mem[pa] = pd;
        if (gs && !sc && !sw) ref_mem[sa] = sd;
        @(posedge clk);
        @(negedge clk);
        chk(pri_rdata === exp_p, {tag, (gp && pw) ? " R7 pri_rdata" : " R8 pri_rdata hold"},
            int'(pri_rdata), int'(exp_p));
        chk(sec_rdata === exp_s, {tag, (gs && !sc && sw) ? " R7 sec_rdata" : " R8 sec_rdata hold"},
            int'(sec_rdata), int'(exp_s));
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 'x;
        repeat (3) @(negedge clk);
        chk(pri_rdata === 8'd0, "R10 pri_rdata after reset", int'(pri_rdata), 0);
        chk(sec_rdata === 8'd0, "R10 sec_rdata after reset", int'(sec_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 primary fills the store; R6 secondary reads it back
        for (int a = 0; a < 256; a++)
            cyc(0, 0, 8'(a), 8'(a * 7 + 3), 1, 1, 1, 0, 0, "R5 pri write");
        for (int a = 0; a < 256; a++)
            cyc(1, 1, 0, 0, 0, 1, 0, 8'(a), 0, "R6 sec read");
        // R6 secondary overwrites; R5 primary reads back
        for (int a = 0; a < 256; a++)
            cyc(1, 1, 0, 0, 0, 0, 0, 8'(a), 8'(a ^ 8'h5a), "R6 sec write");
        for (int a = 0; a < 256; a++)
            cyc(0, 1, 8'(255 - a), 0, 1, 1, 1, 0, 0, "R5 pri read");

        // R6 chip enable high: write attempts ignored, checked by readback
        for (int a = 0; a < 16; a++)
            cyc(1, 1, 0, 0, 0, 0, 1, 8'(a), 8'hff, "R6 ce high");
        // R3 no requests: live strobes ignored
        for (int a = 16; a < 32; a++)
            cyc(1, 0, 8'(a), 8'hee, 1, 0, 0, 8'(a), 8'hdd, "R3 idle");
        for (int a = 0; a < 32; a++)
            cyc(1, 1, 0, 0, 0, 1, 0, 8'(a), 0, "R3 R6 readback");

        // Grant table, all four request combinations
        cyc(1, 1, 0, 0, 1, 1, 1, 0, 0, "R3 table");
        cyc(1, 1, 0, 0, 0, 1, 1, 0, 0, "R2 table");
        cyc(0, 1, 0, 0, 1, 1, 1, 0, 0, "R1 table");
        cyc(0, 1, 0, 0, 0, 1, 1, 0, 0, "R1 table both");

        // R9 collision: secondary write held off while primary writes
        for (int k = 0; k < 3; k++)
            cyc(0, 0, 8'h40, 8'h11, 0, 0, 0, 8'h41, 8'h99, "R9 R8 held off");
        chk(ref_mem[8'h41] === (8'h41 ^ 8'h5a), "R9 model untouched", int'(ref_mem[8'h41]), int'(8'h41 ^ 8'h5a));
        pri_req_n = 1'b1;
        #1;
        chk(sec_busy_n === 1'b0, "R9 served after release", int'(sec_busy_n), 0);
        cyc(1, 1, 0, 0, 0, 0, 0, 8'h41, 8'h99, "R9 served");
        cyc(0, 1, 8'h41, 0, 1, 1, 1, 0, 0, "R9 readback sec word");
        cyc(0, 1, 8'h40, 0, 1, 1, 1, 0, 0, "R9 readback pri word");

        // Random mix, including frequent same-cycle contention
        for (int n = 0; n < 4000; n++)
            cyc(1'($urandom), 1'($urandom), 8'($urandom % 64), 8'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                8'($urandom % 64), 8'($urandom), "R5 R6 R8 mix");
        for (int a = 0; a < 64; a++)
            cyc(1, 1, 0, 0, 0, 1, 0, 8'(a), 0, "R7 final readback");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule